// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch Unit

This block feeds an execute stage with whole instructions of an 8-bit accumulator-style instruction set, while memory delivers one byte per clock. It reads the opcode at the program counter, works out from the opcode alone whether the instruction takes 1, 2 or 3 bytes, and then reads the operand bytes one per cycle. The first operand byte is the low half of a 16-bit operand and the second one is the high half. When the instruction is complete, the block offers the opcode, both operand bytes and the length on a valid/ready output.

The memory port is a plain address and read strobe, with read data returned in the same cycle. The execute stage redirects fetch for jumps and branches by pulsing a load request together with the new address. The load wins over every other action and drops whatever is partly fetched or waiting. All state sits in flip-flops on one rising clock edge. Reset is synchronous.

Top module: `ifu_byte_fetch`

## Requirements
- R1: While `rst` is high, at each clock edge the program counter loads `rst_vec`, `out_valid` drops to 0 and the sequencer returns to opcode fetch. The first read after reset is at `rst_vec`.
- R2: The instruction length depends only on the opcode. For a low nibble of 1, 4, 5 or 6 it is 2. For a low nibble of C, D or E it is 3. For a low nibble of 3, 7, 8, A, B or F it is 1. For a low nibble of 2 it is 2 when the high nibble is even and 1 when it is odd. For a low nibble of 9 it is 2 when the high nibble is even and 3 when it is odd. For a low nibble of 0 it is 2 when the high nibble is odd. With an even high nibble and a low nibble of 0, the length is 3 for high nibble 2, 2 for high nibbles A, C and E, and 1 for high nibbles 0, 4, 6 and 8. So 0x00 and 0xEA are 1 byte, 0x09 is 2 bytes, and 0x4C and 0x6C are 3 bytes.
- R3: The byte at opcode address + 1 appears on `out_lo` and the byte at opcode address + 2 appears on `out_hi` (little-endian).
- R4: There is at most one memory read per clock. Reads use consecutive addresses, and an instruction of length L makes exactly L reads.
- R5: Operand bytes that the instruction does not use read as 0x00.
- R6: `out_len` reports the length as the binary value 1, 2 or 3. It is never 0 while `out_valid` is high.
- R7: While `out_valid` is high and `out_ready` is low, the opcode, operands and length stay unchanged and `mem_rd` stays low.
- R8: In a cycle with `ld_pc` high, no read is issued and `out_valid` is low. The next read is at `ld_addr`, and any partly fetched instruction is dropped.
- R9: A complete instruction that is still waiting when `ld_pc` is asserted is discarded and is never handed over.
- R10: When an instruction is accepted and `ld_pc` is low, the next opcode read happens in the following cycle, at the address just after the last byte of the accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rst_vec | input | ADDR_W | Start address loaded on reset |
| mem_addr | output | ADDR_W | Memory read address (current PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Read data, same cycle as the address |
| ld_pc | input | 1 | Redirect request from execute |
| ld_addr | input | ADDR_W | Redirect target address |
| out_valid | output | 1 | Complete instruction offered |
| out_ready | input | 1 | Execute stage accepts the instruction |
| out_opcode | output | DATA_W | Opcode byte |
| out_lo | output | DATA_W | First operand byte, or zero |
| out_hi | output | DATA_W | Second operand byte, or zero |
| out_len | output | 2 | Instruction length in bytes |

## Verification
A wrong length decode shows up within one instruction. The read count differs from the expected length, and every later opcode is taken from a shifted address, so the next handshake already shows a wrong opcode. A fault in the sequencer or the lane capture shows up at the first instruction that uses the affected byte: an operand moved to the wrong lane, or a non-zero byte in an unused lane. A broken hold or redirect path shows up in the same cycle or the next one, as a read strobe during a stall, a changed output byte, or a first read that is not at the load address.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
   typedef enum logic [1:0] {
      ST_OPC = 2'd0,
      ST_LO  = 2'd1,
      ST_HI  = 2'd2,
      ST_OUT = 2'd3
   } ifu_state_t;

   typedef logic [1:0] ilen_t;
endpackage

// File: rtl/ifu_len_dec.sv
module ifu_len_dec #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opc,
   output ifu_pkg::ilen_t    len
);
   if (DATA_W != 8) begin : g_bad_w
      $error("ifu_len_dec: opcode map is defined for 8-bit opcodes only");
   end

   logic [1:0] grp;
   logic [2:0] mode;
   logic [2:0] op_hi;

   assign grp   = opc[1:0];
   assign mode  = opc[4:2];
   assign op_hi = opc[7:5];

   always_comb begin
      len = 2'd1;
      unique case (grp)
         2'b01: len = (mode == 3'd3 || mode >= 3'd6) ? 2'd3 : 2'd2;
         2'b10: begin
            case (mode)
               3'd0, 3'd1, 3'd5: len = 2'd2;
               3'd3, 3'd7:       len = 2'd3;
               default:          len = 2'd1;
            endcase
         end
         2'b00: begin
            case (mode)
               3'd0: begin
                  if (op_hi == 3'd1)       len = 2'd3;
                  else if (op_hi >= 3'd5)  len = 2'd2;
                  else                     len = 2'd1;
               end
               3'd1, 3'd4, 3'd5: len = 2'd2;
               3'd3, 3'd7:       len = 2'd3;
               default:          len = 2'd1;
            endcase
         end
         default: len = 2'd1;
      endcase
   end
endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rst_vec,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              inc,
   output logic [ADDR_W-1:0] pc
);
   if (ADDR_W < 8) begin : g_bad_a
      $error("ifu_pc_reg: ADDR_W must be at least 8");
   end

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (rst)      pc <= rst_vec;
      else if (ld)  pc <= ld_addr;
      else if (inc) pc <= pc + STEP;
   end

   // R8
   pc_load_chk: assert property (@(posedge clk) disable iff (rst)
      ld |=> pc == $past(ld_addr));

   // R4
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (inc && !ld) |=> pc == $past(pc) + STEP);
endmodule

// File: rtl/ifu_seq.sv
module ifu_seq #(
   parameter int DATA_W   = 8,
   parameter int NUM_OPND = 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             ld,
   input  logic [DATA_W-1:0]                rdata,
   input  ifu_pkg::ilen_t                   dec_len,
   input  logic                             out_ready,
   output logic                             mem_rd,
   output logic                             out_valid,
   output logic [DATA_W-1:0]                opcode,
   output logic [NUM_OPND-1:0][DATA_W-1:0]  opnd,
   output ifu_pkg::ilen_t                   len_q
);
   import ifu_pkg::*;

   if (NUM_OPND != 2) begin : g_bad_n
      $error("ifu_seq: sequencer states cover exactly two operand lanes");
   end

   ifu_state_t state;
   logic       cap_opc;

   assign mem_rd    = (state != ST_OUT) && !ld;
   assign out_valid = (state == ST_OUT) && !ld;
   assign cap_opc   = mem_rd && (state == ST_OPC);

   always_ff @(posedge clk) begin
      if (rst || ld) begin
         state <= ST_OPC;
      end else begin
         unique case (state)
            ST_OPC:  state <= (dec_len == 2'd1) ? ST_OUT : ST_LO;
            ST_LO:   state <= (len_q == 2'd2) ? ST_OUT : ST_HI;
            ST_HI:   state <= ST_OUT;
            ST_OUT:  if (out_ready) state <= ST_OPC;
            default: state <= ST_OPC;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         opcode <= '0;
         len_q  <= 2'd1;
      end else if (cap_opc) begin
         opcode <= rdata;
         len_q  <= dec_len;
      end
   end

   for (genvar k = 0; k < NUM_OPND; k++) begin : g_lane
      localparam ifu_state_t LANE_ST = ifu_state_t'(k + 1);
      logic [DATA_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (rst || cap_opc)                     lane_q <= '0;
         else if (mem_rd && state == LANE_ST)    lane_q <= rdata;
      end
      assign opnd[k] = lane_q;
   end

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> ($stable(opcode) && $stable(opnd) && $stable(len_q)));

   // R9
   ld_flush_chk: assert property (@(posedge clk) disable iff (rst)
      ld |=> !out_valid);

   // R3
   hi_lane_len_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HI) |-> len_q == 2'd3);
endmodule

// File: rtl/ifu_byte_fetch.sv
module ifu_byte_fetch #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int MAX_LEN = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rst_vec,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              ld_pc,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_opcode,
   output logic [DATA_W-1:0] out_lo,
   output logic [DATA_W-1:0] out_hi,
   output logic [1:0]        out_len
);
   localparam int NUM_OPND = MAX_LEN - 1;

   if (MAX_LEN != 3) begin : g_bad_len
      $error("ifu_byte_fetch: MAX_LEN must be 3");
   end

   ifu_pkg::ilen_t                  dec_len;
   ifu_pkg::ilen_t                  len_q;
   logic [NUM_OPND-1:0][DATA_W-1:0] opnd;
   logic                            inc;

   ifu_len_dec #(.DATA_W(DATA_W)) u_dec (
      .opc (mem_rdata),
      .len (dec_len)
   );

   ifu_seq #(.DATA_W(DATA_W), .NUM_OPND(NUM_OPND)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .ld        (ld_pc),
      .rdata     (mem_rdata),
      .dec_len   (dec_len),
      .out_ready (out_ready),
      .mem_rd    (mem_rd),
      .out_valid (out_valid),
      .opcode    (out_opcode),
      .opnd      (opnd),
      .len_q     (len_q)
   );

   assign inc = mem_rd;

   ifu_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
      .clk     (clk),
      .rst     (rst),
      .rst_vec (rst_vec),
      .ld      (ld_pc),
      .ld_addr (ld_addr),
      .inc     (inc),
      .pc      (mem_addr)
   );

   assign out_lo  = opnd[0];
   assign out_hi  = opnd[1];
   assign out_len = len_q;

   // R6
   len_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_len != 2'd0);

   // R7
   stall_no_read_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && !ld_pc) |=> !mem_rd);
endmodule

// File: tb/tb_ifu_byte_fetch.sv
module tb_ifu_byte_fetch;
   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] rst_vec;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata;
   logic        ld_pc;
   logic [15:0] ld_addr;
   logic        out_valid;
   logic        out_ready;
   logic [7:0]  out_opcode, out_lo, out_hi;
   logic [1:0]  out_len;

   logic [7:0] mem [256];
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:0]];

   ifu_byte_fetch dut (
      .clk(clk), .rst(rst), .rst_vec(rst_vec),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .ld_pc(ld_pc), .ld_addr(ld_addr),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_opcode(out_opcode), .out_lo(out_lo), .out_hi(out_hi), .out_len(out_len)
   );

   function automatic int ref_len(input logic [7:0] op);
      logic [3:0] lo = op[3:0];
      logic [3:0] hi = op[7:4];
      case (lo)
         4'h1, 4'h4, 4'h5, 4'h6:       return 2;
         4'hC, 4'hD, 4'hE:             return 3;
         4'h2:                         return hi[0] ? 1 : 2;
         4'h9:                         return hi[0] ? 3 : 2;
         4'h0: begin
            if (hi[0])                 return 2;
            if (hi == 4'h2)            return 3;
            if (hi >= 4'hA)            return 2;
            return 1;
         end
         default:                      return 1;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   initial begin
      logic [15:0] exp_p, nxt;
      int reads, idle, e_len;
      logic [7:0] e_op, e_lo, e_hi;
      bit hold_prev, acc_prev;
      logic [7:0] s_op, s_lo, s_hi;
      logic [1:0] s_len;
      bit done = 0;

      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom(32'd1234) & 0) | 8'($urandom);
      // directed opening stream at 0x10
      mem[8'h10] = 8'h00;
      mem[8'h11] = 8'h09; mem[8'h12] = 8'h5A;
      mem[8'h13] = 8'h4C; mem[8'h14] = 8'h34; mem[8'h15] = 8'h12;
      mem[8'h16] = 8'h6C; mem[8'h17] = 8'hCD; mem[8'h18] = 8'hAB;
      mem[8'h19] = 8'hEA;
      mem[8'h1A] = 8'hA0; mem[8'h1B] = 8'h77;

      rst = 1'b1; rst_vec = 16'h0010; ld_pc = 1'b0; ld_addr = '0; out_ready = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      chk(mem_addr == 16'h0010, "R1", "pc after reset", mem_addr, 16'h0010);
      rst = 1'b0;

      exp_p = 16'h0010; nxt = 16'h0010; reads = 0; idle = 0;
      hold_prev = 0; acc_prev = 0;
      s_op = '0; s_lo = '0; s_hi = '0; s_len = '0;

      for (int cyc = 0; cyc < 6000 && !done; cyc++) begin
         if (cyc > 0) @(negedge clk);
         out_ready = (cyc < 20) ? 1'b1 : (($urandom % 4) != 0);
         ld_pc     = (cyc > 40) && (($urandom % 30) == 0);
         ld_addr   = 16'($urandom);
         #1;
         if (ld_pc) begin
            // R8 / R9: redirect cycle issues nothing and offers nothing
            chk(!mem_rd, "R8", "mem_rd during load", mem_rd, 0);
            chk(!out_valid, "R9", "out_valid during load", out_valid, 0);
            exp_p = ld_addr; nxt = ld_addr; reads = 0;
            hold_prev = 0; acc_prev = 0;
         end else begin
            if (acc_prev)
               // R10
               chk(mem_rd, "R10", "read right after accept", mem_rd, 1);
            if (mem_rd) begin
               // R4
               chk(mem_addr == nxt, "R4", "read address", mem_addr, nxt);
               nxt++; reads++;
            end
            if (hold_prev && out_valid) begin
               // R7
               chk(out_opcode == s_op && out_lo == s_lo && out_hi == s_hi && out_len == s_len,
                   "R7", "held instruction", {out_opcode, out_lo, out_hi}, {s_op, s_lo, s_hi});
            end
            if (out_valid)
               chk(!mem_rd, "R7", "read while offered", mem_rd, 0);
            acc_prev = 0;
            if (out_valid && out_ready) begin
               e_op  = mem[exp_p[7:0]];
               e_len = ref_len(e_op);
               e_lo  = (e_len > 1) ? mem[8'(exp_p + 16'd1)] : 8'h00;
               e_hi  = (e_len > 2) ? mem[8'(exp_p + 16'd2)] : 8'h00;
               chk(out_opcode == e_op, "R2", "opcode", out_opcode, e_op);
               chk(int'(out_len) == e_len, "R6", "length", out_len, e_len);
               // R3 low/high order, R5 zero fill
               chk(out_lo == e_lo, (e_len > 1) ? "R3" : "R5", "operand lo", out_lo, e_lo);
               chk(out_hi == e_hi, (e_len > 2) ? "R3" : "R5", "operand hi", out_hi, e_hi);
               chk(reads == e_len, "R4", "reads per instruction", reads, e_len);
               exp_p = exp_p + 16'(e_len); reads = 0; idle = 0; acc_prev = 1;
            end else begin
               idle++;
            end
            hold_prev = out_valid && !out_ready;
            s_op = out_opcode; s_lo = out_lo; s_hi = out_hi; s_len = out_len;
         end
         if (idle > 200) begin
            chk(1'b0, "R4", "watchdog: no instruction delivered", idle, 0);
            done = 1;
         end
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule